// File: doc/BRIEF.md
# Offset Shadow Store with Limited Programming

This block keeps five byte registers of a sensor register map in step with a small non-volatile image: three per-axis offset bytes and two general-purpose bytes. The host reaches everything through a plain byte write port and a combinational read port. A control register offers two command bits. A load copies the stored image back into the live registers. A program copies the live registers into the image.

Programming is guarded three ways. The storage must report ready, an unlock bit must already be set, and a four-bit count of remaining programs must be nonzero. Each program uses up one count. The block also keeps a 16-bit internal form of each axis offset. One stored step equals eight internal steps. A calibration port can write the internal form directly, and the block then derives the stored byte from it. A soft-reset command restores all backed registers from the image.

The image is held in flip-flops. Its power-up content and the initial program count are parameters.

Top module: `nvm_ofs_shadow`

## Requirements
- R1: After reset the control register reads 0xF0 while the ready input is low. The five live registers equal the parameter image. Each internal offset is its stored byte sign-extended and shifted left by 3. The internal offsets appear on `ofs_int`: X in bits [15:0], Y in [31:16], Z in [47:32].
- R2: The ready bit (control bit 2) is `nvm_rdy` registered once. While it is clear, load and program requests change neither the live registers, the image nor the remaining count.
- R3: A control write with bit 3 (load) set, while ready, copies the image into the offset registers (addresses 1 to 3) and the general-purpose registers (addresses 4 and 5). It also refreshes the internal offsets from the image.
- R4: A control write with bit 1 (program) set, while ready, acts only when the unlock bit (control bit 0) was already set before that write and the remaining count (bits [7:4]) is nonzero. It copies the five live registers into the image and decrements the count by one.
- R5: When the remaining count is zero, program requests leave both the image and the count unchanged.
- R6: A control write stores only bit 0. Bits 1 and 3 always read back as 0. Bits [7:4] and bit 2 are not affected by the written data.
- R7: A host write to an offset register stores the byte. It also sets that axis's internal offset to the byte times 8 in two's complement.
- R8: A calibration strobe for axis 0, 1 or 2 sets that internal offset to `cal_value`. It sets the stored byte to `cal_value` bits [9:3] with bit 15 placed in bit 7. A strobe is ignored in any cycle with `wr_en` high, and it is ignored for axis 3.
- R9: Writing `SRST_CODE` (default 0xA5) to address 6 restores the live registers and internal offsets from the image, whatever the ready state. It also clears the unlock bit and keeps the remaining count. Any other value written to address 6 has no effect.
- R10: Address map: 0 is control, 1 to 3 are the X, Y and Z offsets, 4 and 5 are general purpose. Addresses 6 and 7 read 0, and writes to address 7 are ignored.
- R11: A single control write with both load and program set, while programming is allowed, first restores the live registers from the image, then snapshots them. The image is left unchanged and the count is decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| nvm_rdy | input | 1 | Storage ready status |
| cal_valid | input | 1 | Calibration update strobe |
| cal_axis | input | 2 | Axis selected by the calibration update |
| cal_value | input | 16 | New internal offset value |
| ofs_int | output | 48 | Internal 16-bit offsets of the three axes |

## Verification
The hardest state to reach is an empty remaining count. The stimulus gets there by unlocking once and then issuing fifteen back-to-back program writes. It then proves that a further program is inert by changing a live offset, requesting a program, and running a load that must bring back the older stored value. The bench uses the same load-then-observe method whenever the image itself has to be seen, because the image has no read path of its own. This covers a program blocked by the lock, a program blocked because ready is low, and a combined load and program in one write.

// File: rtl/nvm_ofs_pkg.sv
package nvm_ofs_pkg;
  localparam int NVM_W   = 8;
  localparam int OFS_W   = 16;
  localparam int SHIFT   = 3;
  localparam int N_AXES  = 3;
  localparam int N_SLOTS = 5;
  localparam int ADDR_W  = 3;
  localparam int AX_W    = 2;
  localparam int REM_W   = 4;

  // control register layout
  localparam int CTL_UNLOCK = 0;
  localparam int CTL_PROG   = 1;
  localparam int CTL_RDY    = 2;
  localparam int CTL_LOAD   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SLOT0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_SRST  = 3'd6;

  // stored byte -> internal offset (times 8, sign kept)
  function automatic logic [OFS_W-1:0] nvm2int(input logic [NVM_W-1:0] n);
    return {{(OFS_W-NVM_W-SHIFT){n[NVM_W-1]}}, n, {SHIFT{1'b0}}};
  endfunction

  // internal offset -> stored byte (drop low bits, keep sign)
  function automatic logic [NVM_W-1:0] int2nvm(input logic [OFS_W-1:0] v);
    return {v[OFS_W-1], v[SHIFT+NVM_W-2:SHIFT]};
  endfunction
endpackage

// File: rtl/nvm_ofs_ctrl.sv
module nvm_ofs_ctrl
  import nvm_ofs_pkg::*;
#(
  parameter logic [REM_W-1:0] INIT_REMAIN = 4'hF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nvm_rdy,
  input  logic             wr_ctrl_i,
  input  logic             srst_i,
  input  logic [NVM_W-1:0] wdata_i,
  output logic             load_o,
  output logic             prog_o,
  output logic [NVM_W-1:0] ctrl_rd_o
);
  logic             rdy_q;
  logic             unlock_q, unlock_d, unlock_en;
  logic [REM_W-1:0] remain_q, remain_d;
  logic             remain_en;

  always_comb begin
    load_o    = wr_ctrl_i & rdy_q & wdata_i[CTL_LOAD];
    prog_o    = wr_ctrl_i & rdy_q & wdata_i[CTL_PROG] & unlock_q & (remain_q != '0);
    unlock_en = wr_ctrl_i | srst_i;
    unlock_d  = srst_i ? 1'b0 : wdata_i[CTL_UNLOCK];
    remain_en = prog_o;
    remain_d  = remain_q - 1'b1;
    ctrl_rd_o = '0;
    ctrl_rd_o[NVM_W-1:NVM_W-REM_W] = remain_q;
    ctrl_rd_o[CTL_RDY]    = rdy_q;
    ctrl_rd_o[CTL_UNLOCK] = unlock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      unlock_q <= 1'b0;
      remain_q <= INIT_REMAIN;
    end else begin
      rdy_q <= nvm_rdy;
      if (unlock_en) unlock_q <= unlock_d;
      if (remain_en) remain_q <= remain_d;
    end
  end

  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q != $past(remain_q)) |-> (remain_q == $past(remain_q) - 1'b1)); // R4
  AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && !unlock_q) |=> $stable(remain_q)); // R4
  AST_NOT_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_q) |=> $stable(remain_q)); // R2
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q == '0) |=> (remain_q == '0)); // R5
endmodule

// File: rtl/nvm_ofs_image.sv
module nvm_ofs_image
  import nvm_ofs_pkg::*;
#(
  parameter logic [N_SLOTS*NVM_W-1:0] INIT_IMAGE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_i,
  input  logic [N_SLOTS*NVM_W-1:0] snap_i,
  output logic [N_SLOTS*NVM_W-1:0] image_o
);
  logic [N_SLOTS*NVM_W-1:0] image_q;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [NVM_W-1:0] nxt;
    always_comb nxt = snap_i[s*NVM_W +: NVM_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      image_q[s*NVM_W +: NVM_W] <= INIT_IMAGE[s*NVM_W +: NVM_W];
      else if (prog_i) image_q[s*NVM_W +: NVM_W] <= nxt;
    end
  end

  assign image_o = image_q;

  AST_IMAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_i) |=> $stable(image_q)); // R4
endmodule

// File: rtl/nvm_ofs_live.sv
module nvm_ofs_live
  import nvm_ofs_pkg::*;
#(
  parameter logic [N_SLOTS*NVM_W-1:0] INIT_IMAGE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restore_i,
  input  logic [N_SLOTS*NVM_W-1:0] image_i,
  input  logic [N_SLOTS-1:0]       wr_slot_i,
  input  logic                     wr_any_i,
  input  logic [NVM_W-1:0]         wdata_i,
  input  logic                     cal_valid_i,
  input  logic [AX_W-1:0]          cal_axis_i,
  input  logic [OFS_W-1:0]         cal_value_i,
  output logic [N_SLOTS*NVM_W-1:0] live_o,
  output logic [N_AXES*OFS_W-1:0]  ofs_o
);
  logic [N_SLOTS*NVM_W-1:0] live_q;
  logic [N_AXES*OFS_W-1:0]  ofs_q;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [NVM_W-1:0] img, nxt;
    logic             en;
    logic             cal_take;
    logic [OFS_W-1:0] ofs_nxt;

    always_comb img = image_i[s*NVM_W +: NVM_W];

    if (s < N_AXES) begin : g_axis
      always_comb begin
        cal_take = cal_valid_i & ~wr_any_i & (cal_axis_i == AX_W'(s));
        en       = restore_i | wr_slot_i[s] | cal_take;
        if (restore_i)         nxt = img;
        else if (wr_slot_i[s]) nxt = wdata_i;
        else                   nxt = int2nvm(cal_value_i);
        if (restore_i)         ofs_nxt = nvm2int(img);
        else if (wr_slot_i[s]) ofs_nxt = nvm2int(wdata_i);
        else                   ofs_nxt = cal_value_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ofs_q[s*OFS_W +: OFS_W] <= nvm2int(INIT_IMAGE[s*NVM_W +: NVM_W]);
        else if (en) ofs_q[s*OFS_W +: OFS_W] <= ofs_nxt;
      end
    end else begin : g_gp
      always_comb begin
        cal_take = 1'b0;
        ofs_nxt  = '0;
        en       = restore_i | wr_slot_i[s];
        nxt      = restore_i ? img : wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  live_q[s*NVM_W +: NVM_W] <= INIT_IMAGE[s*NVM_W +: NVM_W];
      else if (en) live_q[s*NVM_W +: NVM_W] <= nxt;
    end
  end

  assign live_o = live_q;
  assign ofs_o  = ofs_q;

  AST_CAL_BAD_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_valid_i && !wr_any_i && (cal_axis_i >= AX_W'(N_AXES))) |=> $stable(ofs_q)); // R8
  AST_CAL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_valid_i && wr_any_i && (wr_slot_i == '0) && !restore_i) |=> $stable(ofs_q)); // R8
endmodule

// File: rtl/nvm_ofs_shadow.sv
module nvm_ofs_shadow
  import nvm_ofs_pkg::*;
#(
  parameter logic [N_SLOTS*NVM_W-1:0] INIT_IMAGE  = {8'hA7, 8'h3C, 8'h80, 8'hFE, 8'h05},
  parameter logic [REM_W-1:0]         INIT_REMAIN = 4'hF,
  parameter logic [NVM_W-1:0]         SRST_CODE   = 8'hA5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NVM_W-1:0]        wdata,
  output logic [NVM_W-1:0]        rdata,
  input  logic                    nvm_rdy,
  input  logic                    cal_valid,
  input  logic [AX_W-1:0]         cal_axis,
  input  logic [OFS_W-1:0]        cal_value,
  output logic [N_AXES*OFS_W-1:0] ofs_int
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic                     wr_ctrl, wr_srst, load, prog;
  logic [N_SLOTS-1:0]       wr_slot;
  logic [NVM_W-1:0]         ctrl_rd;
  logic [N_SLOTS*NVM_W-1:0] image, live, snap;

  always_comb begin
    wr_ctrl = wr_en & (addr == A_CTRL);
    wr_srst = wr_en & (addr == A_SRST) & (wdata == SRST_CODE);
    for (int s = 0; s < N_SLOTS; s++)
      wr_slot[s] = wr_en & (addr == A_SLOT0 + ADDR_W'(s));
    snap = load ? image : live;
  end

  nvm_ofs_ctrl #(.INIT_REMAIN(INIT_REMAIN)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .nvm_rdy(nvm_rdy),
    .wr_ctrl_i(wr_ctrl), .srst_i(wr_srst), .wdata_i(wdata),
    .load_o(load), .prog_o(prog), .ctrl_rd_o(ctrl_rd)
  );

  nvm_ofs_image #(.INIT_IMAGE(INIT_IMAGE)) u_image (
    .clk(clk), .rst_n(rst_i_n), .prog_i(prog), .snap_i(snap), .image_o(image)
  );

  nvm_ofs_live #(.INIT_IMAGE(INIT_IMAGE)) u_live (
    .clk(clk), .rst_n(rst_i_n), .restore_i(load | wr_srst), .image_i(image),
    .wr_slot_i(wr_slot), .wr_any_i(wr_en), .wdata_i(wdata),
    .cal_valid_i(cal_valid), .cal_axis_i(cal_axis), .cal_value_i(cal_value),
    .live_o(live), .ofs_o(ofs_int)
  );

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata = ctrl_rd;
    for (int s = 0; s < N_SLOTS; s++)
      if (addr == A_SLOT0 + ADDR_W'(s)) rdata = live[s*NVM_W +: NVM_W];
  end

  AST_LOAD_RESTORE: assert property (@(posedge clk) disable iff (!rst_i_n)
    load |=> (live == $past(image))); // R3
  AST_SRST_RESTORE: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_srst |=> (live == $past(image))); // R9
  AST_PROG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (prog && !load) |=> (image == $past(live))); // R4
endmodule

// File: tb/sim_nvm_ofs_shadow.sv
module sim_nvm_ofs_shadow;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, nvm_rdy, cal_valid;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [1:0]  cal_axis;
  logic [15:0] cal_value;
  logic [47:0] ofs_int;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  nvm_ofs_shadow u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .nvm_rdy(nvm_rdy), .cal_valid(cal_valid),
    .cal_axis(cal_axis), .cal_value(cal_value), .ofs_int(ofs_int)
  );

  // {write addr, write data, read addr, expected, requirement}
  localparam logic [25:0] VEC [0:17] = '{
    {3'd1, 8'h12, 3'd1, 8'h12, 4'd7},   // R7 offset write
    {3'd0, 8'h02, 3'd0, 8'hF4, 4'd4},   // R4 program while locked
    {3'd0, 8'h01, 3'd0, 8'hF5, 4'd6},   // R6 unlock stored
    {3'd0, 8'h03, 3'd0, 8'hE5, 4'd4},   // R4 program, count 15->14
    {3'd1, 8'h77, 3'd1, 8'h77, 4'd7},   // R7
    {3'd4, 8'h99, 3'd4, 8'h99, 4'd10},  // R10 gp register
    {3'd0, 8'h09, 3'd1, 8'h12, 4'd3},   // R3 load brings back programmed X
    {3'd7, 8'hFF, 3'd4, 8'h3C, 4'd10},  // R10 addr 7 ignored, R3 gp restored
    {3'd6, 8'h00, 3'd6, 8'h00, 4'd9},   // R9 non-code write, addr 6 reads 0
    {3'd2, 8'h40, 3'd2, 8'h40, 4'd7},
    {3'd6, 8'hA5, 3'd2, 8'hFE, 4'd9},   // R9 soft reset restores Y
    {3'd3, 8'h00, 3'd0, 8'hE4, 4'd9},   // R9 unlock cleared, count kept
    {3'd0, 8'hFA, 3'd0, 8'hE4, 4'd6},   // R6 only bit 0 stored
    {3'd5, 8'h11, 3'd3, 8'h80, 4'd3},   // R3 load in previous write restored Z
    {3'd0, 8'h0B, 3'd0, 8'hE5, 4'd4},   // R4 program with stale lock ignored
    {3'd1, 8'h5A, 3'd1, 8'h5A, 4'd7},
    {3'd0, 8'h0B, 3'd1, 8'h12, 4'd11},  // R11 load wins for data
    {3'd5, 8'h00, 3'd0, 8'hD5, 4'd11}   // R11 count decremented
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic rdy);
    wr_en = 0; addr = 0; wdata = 0; cal_valid = 0; cal_axis = 0; cal_value = 0;
    nvm_rdy = rdy; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a; #1;
    check(req, {40'd0, rdata}, {40'd0, exp});
  endtask

  task automatic cal(input logic [1:0] ax, input logic [15:0] v);
    cal_valid = 1; cal_axis = ax; cal_value = v;
    @(negedge clk);
    cal_valid = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state with storage not ready
    do_reset(1'b0);
    rd("R1 ctrl", 3'd0, 8'hF0);
    rd("R1 x", 3'd1, 8'h05);
    rd("R1 gp1", 3'd5, 8'hA7);
    check("R1 internal", ofs_int, {16'hFC00, 16'hFFF0, 16'h0028});

    // R2 ready clear blocks load and program
    wr(3'd1, 8'h33);
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h03);
    rd("R2 count unchanged", 3'd0, 8'hF1);
    wr(3'd0, 8'h09);
    rd("R2 load ignored", 3'd1, 8'h33);
    nvm_rdy = 1; @(negedge clk);
    rd("R2 ready bit", 3'd0, 8'hF5);

    // table pass from a fresh state
    do_reset(1'b1);
    for (int i = 0; i < 18; i++) begin
      wr(VEC[i][25:23], VEC[i][22:15]);
      addr = VEC[i][14:12]; #1;
      checks++;
      if (rdata !== VEC[i][11:4]) begin
        errors++;
        $display("FAIL vec %0d R%0d actual=%0h expected=%0h", i, VEC[i][3:0], rdata, VEC[i][11:4]);
      end
    end

    // R7 internal offset from host byte
    wr(3'd1, 8'hF0);
    check("R7 internal x", {32'd0, ofs_int[15:0]}, {32'd0, 16'hFF80});
    wr(3'd2, 8'h7F);
    check("R7 internal y", {32'd0, ofs_int[31:16]}, {32'd0, 16'h03F8});

    // R8 calibration port
    cal(2'd1, 16'h1234);
    rd("R8 stored y", 3'd2, 8'h46);
    cal(2'd2, 16'hFF85);
    rd("R8 stored z", 3'd3, 8'hF0);
    check("R8 internal", ofs_int, {16'hFF85, 16'h1234, 16'hFF80});
    cal(2'd3, 16'h0001);
    check("R8 axis 3 ignored", ofs_int, {16'hFF85, 16'h1234, 16'hFF80});
    cal_valid = 1; cal_axis = 2'd0; cal_value = 16'h0100;
    wr(3'd4, 8'h66);
    cal_valid = 0;
    rd("R8 blocked by write", 3'd1, 8'hF0);

    // R9 soft reset refreshes internal offsets from image (x=12, z=80)
    wr(3'd6, 8'hA5);
    check("R9 internal", {16'hFC00, ofs_int[15:0]}, {ofs_int[47:32], 16'h0090});

    // R5 exhaust the program count
    do_reset(1'b1);
    wr(3'd1, 8'h21);
    wr(3'd0, 8'h01);
    for (int k = 0; k < 15; k++) wr(3'd0, 8'h03);
    rd("R5 count empty", 3'd0, 8'h05);
    wr(3'd1, 8'h44);
    wr(3'd0, 8'h03);
    rd("R5 count stays", 3'd0, 8'h05);
    wr(3'd0, 8'h09);
    rd("R5 image kept", 3'd1, 8'h21);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule